// File: doc/BRIEF.md
# Block Transmit DMA Engine

This engine moves a block of 16-bit words from a word-addressed memory to a byte-wide transmit port. Software programs a 16-bit start address, then writes a 10-bit length register holding the word count minus one. That write starts the transfer. The engine then fetches one word at a time through a synchronous read port with one cycle of latency. It splits each word into bytes and offers them one by one on a valid/ready stream, least significant byte first.

While the transfer runs, the length register reads back live and counts down by one for each word fully sent. When the last word has gone out, the engine raises a one-cycle completion pulse and drops busy. The length register then reads all ones until software loads a new count. The register port is a plain single-cycle write strobe with a select bit and a combinational read.

Top module: `blk_tx_dma`

## Requirements
- R1: After reset the base register reads 0x0000, the count register reads 0x0000, and `busy`, `done`, `tx_valid` and `mem_rd_en` are all low.
- R2: With `reg_sel`=0 the port reaches the 16-bit base register. A write stores all 16 bits, and a read returns them.
- R3: A write with `reg_sel`=1 while idle starts a transfer. In the cycle after the write edge, `busy` is high, `mem_rd_en` is high and `mem_addr` equals the base register value.
- R4: A count value of N-1 sends exactly N words from consecutive word addresses starting at the base, wrapping modulo 2^16. Each word goes out as bits [7:0] first and then bits [15:8].
- R5: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` does not change on the next cycle.
- R6: The count register decrements by one at the edge on which the high byte of a word is accepted, so during a transfer it reads the number of words still to send minus one.
- R7: At the edge that accepts the final byte, `busy` falls and `done` rises for exactly one cycle. From then on the count register reads 0x3FF until it is written again.
- R8: A count write while `busy` is high is ignored. The count keeps tracking the transfer in progress and no extra words are sent.
- R9: A base write while `busy` is high does not change the words of the transfer in progress. The new base is read back and used by the next transfer.
- R10: Count register bits [15:10] always read zero, and the values written to them have no effect on the transfer length.
- R11: A count of 0x3FF moves 1024 words, which is 2048 bytes, and then completes as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 base address, 1 count |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Combinational read data of the selected register |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory word address |
| mem_rdata | input | 16 | Memory read data, valid one cycle after the request |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Transmit sink ready |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Each result has a fixed latency:
- `busy` and the first fetch address appear in the cycle after the count-write edge.
- The first byte is offered two cycles later.
- The count register changes at the edge that accepts a high byte.
- `done` and the value 0x3FF appear in the cycle after the final handshake.

The monitor samples one time unit after each falling edge. It compares against a counter value that it advances only after it has seen a high-byte handshake in that sample, so every comparison falls one full register stage after its cause. Expected bytes are queued by the driver and popped on each observed handshake, under both a steady sink and a pseudo-random one.

// File: rtl/blk_tx_dma_pkg.sv
package blk_tx_dma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WAIT  = 2'd2,
        ST_SEND  = 2'd3
    } seq_state_e;

    localparam logic SEL_BASE = 1'b0;
    localparam logic SEL_CNT  = 1'b1;

endpackage

// File: rtl/dma_regs.sv
module dma_regs #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 10,
    parameter int REG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              sel,
    input  logic [REG_W-1:0]  wdata,
    input  logic [CNT_W-1:0]  cnt_value,
    output logic [ADDR_W-1:0] base,
    output logic [REG_W-1:0]  rdata
);
    import blk_tx_dma_pkg::*;

    localparam int PAD_W = REG_W - CNT_W;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        if (wr_en && sel == SEL_BASE) begin
            d.base = wdata[ADDR_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign base  = q.base;
    assign rdata = (sel == SEL_CNT) ? {{PAD_W{1'b0}}, cnt_value} : REG_W'(q.base);

    // R2: base only moves when it is written
    a_r2_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && sel == SEL_BASE) |=> $stable(base));

endmodule

// File: rtl/dma_seq.sv
module dma_seq #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 10,
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_wr,
    input  logic [CNT_W-1:0]  start_cnt,
    input  logic [ADDR_W-1:0] base,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    input  logic              tx_ready,
    output logic              busy,
    output logic              done,
    output logic [CNT_W-1:0]  cnt
);
    import blk_tx_dma_pkg::*;

    localparam int LANES  = WORD_W / BYTE_W;
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

    typedef struct packed {
        seq_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] ptr;
        logic [WORD_W-1:0] word;
        logic [LANE_W-1:0] lane;
        logic              done;
    } seq_t;

    seq_t q, d;

    logic [BYTE_W-1:0] lane_bytes [LANES];

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            assign lane_bytes[g] = q.word[g*BYTE_W +: BYTE_W];
        end
    endgenerate

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (start_wr) begin
                    d.cnt   = start_cnt;
                    d.ptr   = base;
                    d.lane  = '0;
                    d.state = ST_FETCH;
                end
            end
            ST_FETCH: begin
                d.state = ST_WAIT;
            end
            ST_WAIT: begin
                d.word  = mem_rdata;
                d.lane  = '0;
                d.state = ST_SEND;
            end
            ST_SEND: begin
                if (tx_ready) begin
                    if (q.lane == LAST_LANE) begin
                        if (q.cnt == '0) begin
                            d.cnt   = '1;
                            d.done  = 1'b1;
                            d.state = ST_IDLE;
                        end else begin
                            d.cnt   = q.cnt - 1'b1;
                            d.ptr   = q.ptr + 1'b1;
                            d.state = ST_FETCH;
                        end
                    end else begin
                        d.lane = q.lane + 1'b1;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign mem_rd_en = (q.state == ST_FETCH);
    assign mem_addr  = q.ptr;
    assign tx_valid  = (q.state == ST_SEND);
    assign tx_data   = lane_bytes[q.lane];
    assign busy      = (q.state != ST_IDLE);
    assign done      = q.done;
    assign cnt       = q.cnt;

    // R5: a stalled byte is held
    a_r5_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R7: completion is a single-cycle pulse
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: the end of a transfer leaves the counter at all ones
    a_r7_cnt_ones: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (cnt == '1));

    // R3: memory is read only during a transfer
    a_r3_rd_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> busy);

    // R8: a count write during a stalled transfer leaves the count alone
    a_r8_cnt_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_wr && !(tx_valid && tx_ready)) |=> $stable(cnt));

endmodule

// File: rtl/blk_tx_dma.sv
module blk_tx_dma #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 10,
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8,
    parameter int REG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    input  logic              tx_ready,
    output logic              busy,
    output logic              done
);
    import blk_tx_dma_pkg::*;

    logic [ADDR_W-1:0] base;
    logic [CNT_W-1:0]  cnt;
    logic              cnt_wr;

    assign cnt_wr = reg_wr && (reg_sel == SEL_CNT);

    dma_regs #(
        .ADDR_W(ADDR_W),
        .CNT_W (CNT_W),
        .REG_W (REG_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .sel      (reg_sel),
        .wdata    (reg_wdata),
        .cnt_value(cnt),
        .base     (base),
        .rdata    (reg_rdata)
    );

    dma_seq #(
        .ADDR_W(ADDR_W),
        .CNT_W (CNT_W),
        .WORD_W(WORD_W),
        .BYTE_W(BYTE_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_wr (cnt_wr),
        .start_cnt(reg_wdata[CNT_W-1:0]),
        .base     (base),
        .mem_rd_en(mem_rd_en),
        .mem_addr (mem_addr),
        .mem_rdata(mem_rdata),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_ready (tx_ready),
        .busy     (busy),
        .done     (done),
        .cnt      (cnt)
    );

endmodule

// File: tb/blk_tx_dma_tb.sv
module blk_tx_dma_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b1;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        mem_rd_en;
    logic [15:0] mem_addr;
    logic [15:0] mem_rdata = '0;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b1;
    logic        busy;
    logic        done;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic [7:0] exp_q[$];
    logic [9:0] exp_cnt = '0;
    bit         hs_lane = 1'b0;
    bit         rdy_mode = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    int         bytes_seen = 0;

    always #5 clk = ~clk;

    blk_tx_dma u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_rd_en(mem_rd_en),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_ready(tx_ready), .busy(busy), .done(done)
    );

    function automatic logic [15:0] mem_word(input logic [15:0] a);
        return {a[7:0] + 8'h11, a[7:0] ^ a[15:8] ^ 8'h5A};
    endfunction

    // memory model: one cycle read latency
    always @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= mem_word(mem_addr);
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // sink readiness
    initial begin
        forever begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            tx_ready = rdy_mode ? lfsr[0] : 1'b1;
        end
    end

    // monitor / scoreboard
    initial begin
        bit         prev_stall = 1'b0;
        logic [7:0] prev_data = '0;
        bit         prev_done = 1'b0;
        forever begin
            @(negedge clk);
            #1;
            if (rst_n) begin
                if (reg_sel && !reg_wr)
                    chk(reg_rdata[9:0] == exp_cnt, "R6", "live count",
                        reg_rdata[9:0], exp_cnt);
                if (prev_stall) begin
                    chk(tx_valid == 1'b1, "R5", "valid held", tx_valid, 1);
                    chk(tx_data == prev_data, "R5", "data held", tx_data, prev_data);
                end
                if (done) begin
                    chk(!prev_done, "R7", "done single cycle", prev_done, 0);
                    chk(!busy, "R7", "busy low with done", busy, 0);
                end
                prev_done  = done;
                prev_stall = tx_valid && !tx_ready;
                prev_data  = tx_data;
                if (tx_valid && tx_ready) begin
                    bytes_seen++;
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R4", "unexpected byte", tx_data, 0);
                    end else begin
                        logic [7:0] e;
                        e = exp_q.pop_front();
                        chk(tx_data == e, "R4", "byte", tx_data, e);
                    end
                    if (hs_lane) exp_cnt = (exp_cnt == 10'd0) ? 10'h3FF : exp_cnt - 10'd1;
                    hs_lane = ~hs_lane;
                end
            end
        end
    end

    task automatic reg_write(input bit sel, input logic [15:0] d);
        @(negedge clk);
        reg_sel   = sel;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(posedge clk);
        #1;
        reg_wr  = 1'b0;
        reg_sel = 1'b1;
    endtask

    task automatic read_chk(input bit sel, input logic [15:0] e, input string req);
        @(negedge clk);
        reg_sel = sel;
        #2;
        chk(reg_rdata == e, req, sel ? "count read" : "base read", reg_rdata, e);
        reg_sel = 1'b1;
    endtask

    task automatic start_xfer(input logic [15:0] b, input logic [15:0] c, input bit wr_base);
        int n;
        n = int'(c[9:0]) + 1;
        if (wr_base) reg_write(1'b0, b);
        for (int i = 0; i < n; i++) begin
            logic [15:0] w;
            w = mem_word(b + 16'(i));
            exp_q.push_back(w[7:0]);
            exp_q.push_back(w[15:8]);
        end
        hs_lane    = 1'b0;
        bytes_seen = 0;
        reg_write(1'b1, c);
        exp_cnt = c[9:0];
        chk(busy == 1'b1, "R3", "busy after start", busy, 1);
        chk(mem_rd_en == 1'b1, "R3", "first fetch", mem_rd_en, 1);
        chk(mem_addr == b, "R3", "first address", mem_addr, b);
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!done);
        #1;
        chk(busy == 1'b0, "R7", "busy at done", busy, 0);
        @(negedge clk);
        #2;
        chk(done == 1'b0, "R7", "done drops", done, 0);
        chk(reg_rdata == 16'h03FF, "R7", "count all ones", reg_rdata, 16'h03FF);
        chk(exp_q.size() == 0, "R4", "bytes left over", exp_q.size(), 0);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "WDOG", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #2;
        // R1 reset state
        chk(busy == 0, "R1", "busy", busy, 0);
        chk(done == 0, "R1", "done", done, 0);
        chk(tx_valid == 0, "R1", "tx_valid", tx_valid, 0);
        chk(mem_rd_en == 0, "R1", "mem_rd_en", mem_rd_en, 0);
        read_chk(1'b0, 16'h0000, "R1");
        read_chk(1'b1, 16'h0000, "R1");

        // R2 base register
        reg_write(1'b0, 16'hA55A);
        read_chk(1'b0, 16'hA55A, "R2");
        reg_write(1'b0, 16'hFFFF);
        read_chk(1'b0, 16'hFFFF, "R2");

        // R10 reserved bits set on write: 3 words, steady sink
        start_xfer(16'h0100, 16'hFC02, 1'b1);
        read_chk(1'b1, 16'h0002, "R10");
        wait_done();
        chk(bytes_seen == 6, "R10", "byte total", bytes_seen, 6);

        // R8 and R9 under a stalling sink, address wrap for R4
        rdy_mode = 1'b1;
        start_xfer(16'hFFFE, 16'h0004, 1'b1);
        repeat (6) @(negedge clk);
        chk(busy == 1'b1, "R8", "still busy before writes", busy, 1);
        reg_write(1'b0, 16'h0300);
        reg_write(1'b1, 16'h0000);
        wait_done();
        chk(bytes_seen == 10, "R8", "byte total", bytes_seen, 10);
        read_chk(1'b0, 16'h0300, "R9");

        // R9 next transfer uses the base written while busy
        start_xfer(16'h0300, 16'h0001, 1'b0);
        wait_done();

        // R11 largest block
        rdy_mode = 1'b0;
        start_xfer(16'h2000, 16'h03FF, 1'b1);
        wait_done();
        chk(bytes_seen == 2048, "R11", "byte total", bytes_seen, 2048);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule